// File: doc/BRIEF.md
# Serial Register-Access Slave with Selectable Bit Order

This block is a serial peripheral slave that gives a host access to a register space of one byte per address. A frame opens when chip select goes low. The host first sends a 16-bit instruction made of a read/write flag and a 15-bit address. Data bytes then follow until chip select goes high. After each byte the address pointer steps to the next address. The direction of that step depends on the selected bit order.

A configuration byte at address 0 controls the interface. It selects whether read data leaves on a dedicated output pin or on the shared bidirectional pin, and whether bits travel MSB-first or LSB-first. It also holds a self-clearing soft-reset bit and a reserved bit that always reads 1. The upper nibble is reflected into the lower nibble. A host can therefore write a mirror-symmetric byte that arrives intact whatever order the slave currently expects.

The serial pins are oversampled in the system clock domain. The block holds a small demo map at addresses 1 to 4. Addresses 1 and 2 have reset defaults and addresses 3 and 4 have none. Every written byte is also presented on a parallel register-write port.

Top module: `spi_regif`

## Requirements
- R1: An instruction is 16 bits. Bit 15 is the read flag (1 = read) and bits 14:0 are the start address. MSB-first mode sends bit 15 first and LSB-first mode sends bit 0 first. Data bytes follow the instruction until chip select deasserts.
- R2: Configuration bit 7 selects the read-data pin. When it is 1, read data drives `sdo_o` with `sdo_oe_o` high and `sdio_oe_o` low. When it is 0, read data drives `sdio_o` with `sdio_oe_o` high and `sdo_oe_o` low.
- R3: Configuration bit 6 selects the bit order of data bytes in both directions: 1 means LSB first and 0 means MSB first.
- R4: After each data byte, the address pointer decrements in MSB-first mode and increments in LSB-first mode. It wraps modulo 2^15, so 0x0000 and 0x7FFF are neighbours.
- R5: Writing 1 to configuration bit 5 does three things. Registers with a default (address 1 = 0xA5, address 2 = 0x3C) return to their defaults. Addresses 3 and 4 and configuration bits 7 and 6 keep their values. Bit 5 then clears itself within one clock.
- R6: Configuration bit 4 always reads 1 and ignores writes. A read of address 0 returns {b7,b6,b5,1,1,b5,b6,b7}. The lower nibble of a write to address 0 is ignored.
- R7: After a hardware reset, address 0 reads 0x18, address 1 reads 0xA5, address 2 reads 0x3C, and addresses 3 and 4 read 0x00.
- R8: A write to address 0 updates the stored configuration at once. The new bit order and pin selection take effect only from the next frame, so the remaining bytes of the current frame keep the old ones.
- R9: An output enable is high only during the data phase of a read frame. Neither enable is ever high during an instruction phase, during a write frame, or after chip select deasserts.
- R10: Each completed data byte of a write frame pulses `reg_wr_o` for one clock, with its address and byte, at any address. Addresses outside 0 to 4 read as 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to oversample the serial pins |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_ni | input | 1 | Active-low chip select |
| sclk_i | input | 1 | Serial clock, idle low; input sampled on rise, output launched on fall |
| sdio_i | input | 1 | Serial data input from the bidirectional pin |
| sdio_o | output | 1 | Serial read data toward the bidirectional pin |
| sdio_oe_o | output | 1 | Drive enable for the bidirectional pin |
| sdo_o | output | 1 | Serial read data on the dedicated output pin |
| sdo_oe_o | output | 1 | Drive enable for the dedicated output pin |
| reg_wr_o | output | 1 | One-clock strobe for a received write byte |
| reg_addr_o | output | 15 | Address of the current byte |
| reg_wdata_o | output | 8 | Received write byte |

## Verification
The bench sweeps a stride of byte values through one register in each bit order. Each sweep value is checked both on the parallel write port and by serial readback. The parallel port separates a bit-order fault from a loopback that is merely self-consistent, and the non-palindromic defaults 0xA5 and 0x3C expose a reversed read path. Multi-byte frames that start at addresses 1, 4, 0 and 0x7FFF show whether the pointer steps in the correct direction and wraps. A frame that changes the configuration and then keeps streaming shows whether the new order leaks into the current frame. Output-enable sampling on every bit separates the instruction phase, write frames, and the two read-pin selections.

// File: rtl/spi_regif_pkg.sv
package spi_regif_pkg;

  typedef struct packed {
    logic sdo_en;
    logic lsb_first;
    logic srst;
  } cfg_t;

  // upper nibble mirrored into lower nibble; bit 4 / bit 3 fixed at 1
  function automatic logic [7:0] cfg_byte(cfg_t c);
    return {c.sdo_en, c.lsb_first, c.srst, 1'b1, 1'b1, c.srst, c.lsb_first, c.sdo_en};
  endfunction

endpackage

// File: rtl/spi_regif_sync.sv
module spi_regif_sync #(
  parameter int unsigned      WIDTH   = 3,
  parameter int unsigned      STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [STAGES-1:0][WIDTH-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= RST_VAL;
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/spi_regif_engine.sv
module spi_regif_engine #(
  parameter int unsigned ADDR_W = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_act_i,
  input  logic              sclk_rise_i,
  input  logic              sclk_fall_i,
  input  logic              sdi_i,
  input  logic              lsb_i,
  input  logic [7:0]        rdata_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              wr_o,
  output logic [7:0]        wdata_o,
  output logic              out_bit_o,
  output logic              out_act_o,
  output logic              rd_frame_o
);

  localparam int unsigned       INSTR_W = ADDR_W + 1;
  localparam int unsigned       CNT_W   = $clog2(INSTR_W + 1);
  localparam logic [CNT_W-1:0]  CNT_LAST = CNT_W'(INSTR_W - 1);
  localparam logic [CNT_W-1:0]  CNT_DATA = CNT_W'(INSTR_W);

  logic [CNT_W-1:0]   bit_cnt_q;
  logic [INSTR_W-1:0] instr_q, instr_nx;
  logic [7:0]         rx_q, rx_nx;
  logic [2:0]         dcnt_q, tx_pos;
  logic               rw_q, act_q, out_q;
  logic [ADDR_W-1:0]  ptr_q;
  logic               data_ph, byte_done;

  assign data_ph   = (bit_cnt_q == CNT_DATA);
  assign instr_nx  = lsb_i ? {sdi_i, instr_q[INSTR_W-1:1]} : {instr_q[INSTR_W-2:0], sdi_i};
  assign rx_nx     = lsb_i ? {sdi_i, rx_q[7:1]} : {rx_q[6:0], sdi_i};
  assign byte_done = cs_act_i && sclk_rise_i && data_ph && (dcnt_q == 3'd7);
  assign tx_pos    = lsb_i ? dcnt_q : 3'd7 - dcnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_cnt_q <= '0;
      instr_q   <= '0;
      rx_q      <= '0;
      dcnt_q    <= '0;
      rw_q      <= 1'b0;
      act_q     <= 1'b0;
      out_q     <= 1'b0;
      ptr_q     <= '0;
    end else if (!cs_act_i) begin
      bit_cnt_q <= '0;
      dcnt_q    <= '0;
      rw_q      <= 1'b0;
      act_q     <= 1'b0;
    end else begin
      if (sclk_rise_i) begin
        if (!data_ph) begin
          instr_q   <= instr_nx;
          bit_cnt_q <= bit_cnt_q + CNT_W'(1);
          if (bit_cnt_q == CNT_LAST) begin
            rw_q  <= instr_nx[INSTR_W-1];
            ptr_q <= instr_nx[ADDR_W-1:0];
          end
        end else begin
          rx_q   <= rx_nx;
          dcnt_q <= dcnt_q + 3'd1;
          if (dcnt_q == 3'd7) ptr_q <= lsb_i ? ptr_q + ADDR_W'(1) : ptr_q - ADDR_W'(1);
        end
      end
      if (sclk_fall_i && data_ph && rw_q) begin
        act_q <= 1'b1;
        out_q <= rdata_i[tx_pos];
      end
    end
  end

  assign addr_o     = ptr_q;
  assign wr_o       = byte_done && !rw_q;
  assign wdata_o    = rx_nx;
  assign out_bit_o  = out_q;
  assign out_act_o  = act_q;
  assign rd_frame_o = rw_q;

endmodule

// File: rtl/spi_regif_regs.sv
module spi_regif_regs
  import spi_regif_pkg::*;
#(
  parameter int unsigned         ADDR_W   = 15,
  parameter int unsigned         NREG     = 4,
  parameter logic [NREG*8-1:0]   DEF_VAL  = {8'h00, 8'h00, 8'h3C, 8'hA5},
  parameter logic [NREG-1:0]     DEF_MASK = 4'b0011
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [7:0]        wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [7:0]        rdata_o,
  output cfg_t              cfg_o
);

  cfg_t                  cfg_q;
  logic [NREG-1:0][7:0]  regs_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
    end else if (wr_i && waddr_i == '0) begin
      cfg_q <= '{sdo_en: wdata_i[7], lsb_first: wdata_i[6], srst: wdata_i[5]};
    end else if (cfg_q.srst) begin
      cfg_q.srst <= 1'b0;
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic [7:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        q <= DEF_MASK[g] ? DEF_VAL[g*8 +: 8] : 8'h00;
      end else if (wr_i && waddr_i == ADDR_W'(g + 1)) begin
        q <= wdata_i;
      end else if (cfg_q.srst && DEF_MASK[g]) begin
        q <= DEF_VAL[g*8 +: 8];
      end
    end
    assign regs_w[g] = q;
  end

  always_comb begin
    rdata_o = 8'h00;
    if (raddr_i == '0) rdata_o = cfg_byte(cfg_q);
    for (int i = 0; i < NREG; i++) begin
      if (raddr_i == ADDR_W'(i + 1)) rdata_o = regs_w[i];
    end
  end

  assign cfg_o = cfg_q;

endmodule

// File: rtl/spi_regif.sv
module spi_regif
  import spi_regif_pkg::*;
#(
  parameter int unsigned       ADDR_W      = 15,
  parameter int unsigned       NREG        = 4,
  parameter logic [NREG*8-1:0] DEF_VAL     = {8'h00, 8'h00, 8'h3C, 8'hA5},
  parameter logic [NREG-1:0]   DEF_MASK    = 4'b0011,
  parameter int unsigned       SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              sclk_i,
  input  logic              sdio_i,
  output logic              sdio_o,
  output logic              sdio_oe_o,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  output logic              reg_wr_o,
  output logic [ADDR_W-1:0] reg_addr_o,
  output logic [7:0]        reg_wdata_o
);

  logic [2:0]        pins_s;
  logic              cs_act, sclk_s, sclk_d, sdi_s, sclk_rise, sclk_fall;
  logic              lsb_act, sdo_act, out_bit, out_act, rd_frame, srst;
  logic [ADDR_W-1:0] addr;
  logic [7:0]        rdata, wdata;
  logic              wr;
  cfg_t              cfg;

  spi_regif_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({cs_ni, sclk_i, sdio_i}),
    .q_o   (pins_s)
  );

  assign cs_act    = !pins_s[2];
  assign sclk_s    = pins_s[1];
  assign sdi_s     = pins_s[0];
  assign sclk_rise = sclk_s && !sclk_d;
  assign sclk_fall = !sclk_s && sclk_d;

  // order and pin selection only move between frames
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_d  <= 1'b0;
      lsb_act <= 1'b0;
      sdo_act <= 1'b0;
    end else begin
      sclk_d <= sclk_s;
      if (!cs_act) begin
        lsb_act <= cfg.lsb_first;
        sdo_act <= cfg.sdo_en;
      end
    end
  end

  spi_regif_engine #(.ADDR_W(ADDR_W)) i_engine (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cs_act_i   (cs_act),
    .sclk_rise_i(sclk_rise),
    .sclk_fall_i(sclk_fall),
    .sdi_i      (sdi_s),
    .lsb_i      (lsb_act),
    .rdata_i    (rdata),
    .addr_o     (addr),
    .wr_o       (wr),
    .wdata_o    (wdata),
    .out_bit_o  (out_bit),
    .out_act_o  (out_act),
    .rd_frame_o (rd_frame)
  );

  spi_regif_regs #(
    .ADDR_W(ADDR_W), .NREG(NREG), .DEF_VAL(DEF_VAL), .DEF_MASK(DEF_MASK)
  ) i_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (wr),
    .waddr_i(addr),
    .wdata_i(wdata),
    .raddr_i(addr),
    .rdata_o(rdata),
    .cfg_o  (cfg)
  );

  assign srst        = cfg.srst;
  assign sdio_o      = out_bit;
  assign sdo_o       = out_bit;
  assign sdio_oe_o   = out_act && !sdo_act;
  assign sdo_oe_o    = out_act && sdo_act;
  assign reg_wr_o    = wr;
  assign reg_addr_o  = addr;
  assign reg_wdata_o = wdata;

endmodule

// File: rtl/spi_regif_chk.sv
module spi_regif_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic cs_act,
  input logic sdio_oe_o,
  input logic sdo_oe_o,
  input logic rd_frame,
  input logic lsb_act,
  input logic sdo_act,
  input logic srst,
  input logic reg_wr_o
);

  a_r9_oe_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_act |=> !(sdio_oe_o || sdo_oe_o));

  a_r2_oe_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sdio_oe_o && sdo_oe_o));

  a_r9_oe_read_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sdio_oe_o || sdo_oe_o) |-> rd_frame);

  a_r8_cfg_frame_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_act && $past(cs_act)) |-> ($stable(lsb_act) && $stable(sdo_act)));

  a_r5_srst_self_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst |=> !srst);

  a_r10_wr_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_wr_o |=> !reg_wr_o);

endmodule

bind spi_regif spi_regif_chk i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .cs_act   (cs_act),
  .sdio_oe_o(sdio_oe_o),
  .sdo_oe_o (sdo_oe_o),
  .rd_frame (rd_frame),
  .lsb_act  (lsb_act),
  .sdo_act  (sdo_act),
  .srst     (srst),
  .reg_wr_o (reg_wr_o)
);

// File: tb/test_spi_regif.sv
module test_spi_regif;

  localparam int HALF = 5;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cs_ni = 1'b1;
  logic        sclk_i = 1'b0;
  logic        sdio_i = 1'b0;
  logic        sdio_o, sdio_oe_o, sdo_o, sdo_oe_o, reg_wr_o;
  logic [14:0] reg_addr_o;
  logic [7:0]  reg_wdata_o;

  int n_chk = 0;
  int n_fail = 0;
  int wr_cnt = 0;
  logic [14:0] last_addr = '0;
  logic [7:0]  last_data = '0;
  logic h_lsb = 1'b0, h_sdo = 1'b0;
  logic seen_sdio_oe, seen_sdo_oe, ins_oe;

  always #4 clk = ~clk;

  spi_regif i_spi_regif (
    .clk_i(clk), .rst_ni(rst_ni), .cs_ni(cs_ni), .sclk_i(sclk_i), .sdio_i(sdio_i),
    .sdio_o(sdio_o), .sdio_oe_o(sdio_oe_o), .sdo_o(sdo_o), .sdo_oe_o(sdo_oe_o),
    .reg_wr_o(reg_wr_o), .reg_addr_o(reg_addr_o), .reg_wdata_o(reg_wdata_o)
  );

  always @(posedge clk) begin
    if (reg_wr_o) begin
      wr_cnt    <= wr_cnt + 1;
      last_addr <= reg_addr_o;
      last_data <= reg_wdata_o;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic spi_bit(input logic bo, output logic bi);
    sdio_i = bo;
    repeat (HALF) @(negedge clk);
    bi = h_sdo ? sdo_o : sdio_o;
    seen_sdio_oe |= sdio_oe_o;
    seen_sdo_oe  |= sdo_oe_o;
    sclk_i = 1'b1;
    repeat (HALF) @(negedge clk);
    sclk_i = 1'b0;
  endtask

  task automatic begin_frame(input logic rd, input logic [14:0] addr);
    logic [15:0] w;
    logic d;
    w = {rd, addr};
    cs_ni = 1'b0;
    seen_sdio_oe = 1'b0;
    seen_sdo_oe  = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < 16; i++) spi_bit(w[h_lsb ? i : 15 - i], d);
    ins_oe = seen_sdio_oe | seen_sdo_oe;
    seen_sdio_oe = 1'b0;
    seen_sdo_oe  = 1'b0;
  endtask

  task automatic xfer_byte(input logic [7:0] wb, output logic [7:0] rb);
    logic b;
    rb = '0;
    for (int i = 0; i < 8; i++) begin
      spi_bit(wb[h_lsb ? i : 7 - i], b);
      rb[h_lsb ? i : 7 - i] = b;
    end
  endtask

  task automatic end_frame;
    repeat (3) @(negedge clk);
    cs_ni = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic wr_reg(input logic [14:0] a, input logic [7:0] v);
    logic [7:0] r;
    begin_frame(1'b0, a);
    xfer_byte(v, r);
    end_frame();
  endtask

  task automatic rd_reg(input logic [14:0] a, output logic [7:0] v);
    begin_frame(1'b1, a);
    xfer_byte(8'h00, v);
    end_frame();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] r;
    int wc;
    repeat (5) @(negedge clk);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);

    // reset state
    chk("R9 idle oe", {sdio_oe_o, sdo_oe_o}, 0);
    chk("R10 idle wr", reg_wr_o, 0);
    rd_reg(15'h0, r); chk("R7 cfg reset", r, 8'h18);
    rd_reg(15'h1, r); chk("R7 reg1 default", r, 8'hA5);
    chk("R9 rd sdio oe", seen_sdio_oe, 1);
    chk("R2 rd sdo oe off", seen_sdo_oe, 0);
    chk("R9 instr oe", ins_oe, 0);
    rd_reg(15'h2, r); chk("R7 reg2 default", r, 8'h3C);
    rd_reg(15'h3, r); chk("R7 reg3 reset", r, 8'h00);
    rd_reg(15'h4, r); chk("R7 reg4 reset", r, 8'h00);
    rd_reg(15'h5, r); chk("R10 unmapped read", r, 8'h00);

    // R1 R4: MSB-first multi-byte, decrementing
    wc = wr_cnt;
    begin_frame(1'b0, 15'h4);
    xfer_byte(8'h11, r); xfer_byte(8'h22, r); xfer_byte(8'h33, r); xfer_byte(8'h44, r);
    chk("R9 write frame oe", seen_sdio_oe | seen_sdo_oe | ins_oe, 0);
    end_frame();
    chk("R10 wr count", wr_cnt - wc, 4);
    chk("R4 dec last addr", last_addr, 15'h1);
    chk("R10 last data", last_data, 8'h44);
    begin_frame(1'b1, 15'h4);
    xfer_byte(8'h00, r); chk("R4 dec rd a4", r, 8'h11);
    xfer_byte(8'h00, r); chk("R4 dec rd a3", r, 8'h22);
    xfer_byte(8'h00, r); chk("R4 dec rd a2", r, 8'h33);
    xfer_byte(8'h00, r); chk("R1 dec rd a1", r, 8'h44);
    end_frame();

    // R4 wrap downward from 0
    begin_frame(1'b0, 15'h0);
    xfer_byte(8'h18, r); xfer_byte(8'h77, r);
    end_frame();
    chk("R4 dec wrap addr", last_addr, 15'h7FFF);
    chk("R10 unmapped write data", last_data, 8'h77);

    // R3 MSB sweep
    for (int v = 0; v < 256; v += 5) begin
      wr_reg(15'h3, 8'(v));
      chk("R3 msb wr data", last_data, 32'(v));
      rd_reg(15'h3, r);
      chk("R3 msb readback", r, 32'(v));
    end

    // R8: switch to LSB mid-frame, rest of frame stays MSB
    begin_frame(1'b0, 15'h1);
    xfer_byte(8'h69, r); xfer_byte(8'h5A, r); xfer_byte(8'h12, r);
    end_frame();
    chk("R8 same-frame order kept", last_data, 8'h12);
    chk("R8 same-frame addr", last_addr, 15'h7FFF);
    h_lsb = 1'b1;
    rd_reg(15'h0, r); chk("R8 cfg lsb", r, 8'h5A);
    rd_reg(15'h1, r); chk("R3 lsb read a1", r, 8'h69);

    // R3 LSB sweep
    for (int v = 1; v < 256; v += 5) begin
      wr_reg(15'h4, 8'(v));
      chk("R3 lsb wr data", last_data, 32'(v));
      rd_reg(15'h4, r);
      chk("R3 lsb readback", r, 32'(v));
    end

    // R4 increment
    begin_frame(1'b0, 15'h1);
    xfer_byte(8'hA1, r); xfer_byte(8'hB2, r); xfer_byte(8'hC3, r); xfer_byte(8'hD4, r);
    end_frame();
    chk("R4 inc last addr", last_addr, 15'h4);
    begin_frame(1'b1, 15'h1);
    xfer_byte(8'h00, r); chk("R4 inc rd a1", r, 8'hA1);
    xfer_byte(8'h00, r); chk("R4 inc rd a2", r, 8'hB2);
    xfer_byte(8'h00, r); chk("R4 inc rd a3", r, 8'hC3);
    xfer_byte(8'h00, r); chk("R1 inc rd a4", r, 8'hD4);
    end_frame();
    begin_frame(1'b0, 15'h7FFF);
    xfer_byte(8'h55, r); xfer_byte(8'h5A, r);
    end_frame();
    chk("R4 inc wrap addr", last_addr, 15'h0);

    // R6 reserved bit and ignored lower nibble
    wr_reg(15'h0, 8'h42);
    rd_reg(15'h0, r); chk("R6 reserved reads 1", r, 8'h5A);
    wr_reg(15'h0, 8'h47);
    rd_reg(15'h0, r); chk("R6 lower nibble ignored", r, 8'h5A);

    // R5 soft reset
    wr_reg(15'h0, 8'h7E);
    rd_reg(15'h0, r); chk("R5 srst cleared lsb kept", r, 8'h5A);
    rd_reg(15'h1, r); chk("R5 reg1 restored", r, 8'hA5);
    rd_reg(15'h2, r); chk("R5 reg2 restored", r, 8'h3C);
    rd_reg(15'h3, r); chk("R5 reg3 kept", r, 8'hC3);
    rd_reg(15'h4, r); chk("R5 reg4 kept", r, 8'hD4);

    // R2 dedicated output pin
    wr_reg(15'h0, 8'hDB);
    h_sdo = 1'b1;
    rd_reg(15'h1, r); chk("R2 sdo data", r, 8'hA5);
    chk("R2 sdo oe", seen_sdo_oe, 1);
    chk("R2 sdio oe off", seen_sdio_oe, 0);
    rd_reg(15'h0, r); chk("R2 cfg sdo", r, 8'hDB);

    // back to defaults by palindrome
    wr_reg(15'h0, 8'h18);
    h_lsb = 1'b0;
    h_sdo = 1'b0;
    rd_reg(15'h2, r); chk("R3 msb again", r, 8'h3C);
    chk("R2 sdio oe back", seen_sdio_oe, 1);
    chk("R9 idle oe end", {sdio_oe_o, sdo_oe_o}, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule